// File: doc/BRIEF.md
# Timing Reference Selector with Holdover

This block is the digital control core of a network receiver clock. It watches several incoming timing references, each presented as a one-cycle edge strobe in the system clock domain. One reference is active at a time and the others are on standby. Each reference has its own activity monitor. The monitor declares the reference lost after a window with no edges. It declares the reference usable again only after a run of edges that meets the window every time.

A mode state machine chooses the active reference from a software-supplied priority order and follows a lock indication from the external loop. When the active reference fails, the machine moves to the best usable standby. When every reference has failed, it holds the last averaged frequency control word. If holdover is disabled, or when it times out, the machine falls back to free-run with the nominal word of zero. On every reference change, the phase offset to the new reference is loaded into a build-out register, so the output phase does not step. The build-out is clamped to a bound chosen to keep time error within one microsecond. It then bleeds away at a bounded slope chosen below 61 ppm, so that clocks downstream stay locked.

Top module: `refsel_core`

## Requirements
- R1: `active_sel` always holds an index below NREF, and exactly one reference is active in ACQUIRE and LOCKED.
- R2: A reference's `ref_valid` bit falls exactly LOSS_WIN clock cycles after the cycle of its last edge strobe, counting that cycle.
- R3: A reference becomes valid on its QUAL_N-th consecutive edge, provided no gap reaches LOSS_WIN cycles. A reference whose edges are spaced further apart than LOSS_WIN never becomes valid.
- R4: From free-run, the machine enters ACQUIRE on the highest-priority valid reference. Field k of `prio_order` (bits k*IW upward) names the reference of rank k, and rank 0 is the highest. A high `lock_det` in ACQUIRE moves the machine to LOCKED.
- R5: Loss of the active reference while another is valid causes one cycle of SWITCHING and then ACQUIRE on the highest-priority valid standby. The same happens when a reference returns during holdover. The active reference is kept while it stays valid, even when a higher-ranked one qualifies.
- R6: With HOLD_EN=1, loss of all references after a lock enters HOLDOVER. `freq_word` then equals the running average of `cw_in` taken while LOCKED, and it ignores later changes of `cw_in`.
- R7: After HOLD_TMO cycles in HOLDOVER with no valid reference, the machine enters FREERUN and `freq_word` becomes 0.
- R8: With HOLD_EN=0, loss of all references goes straight to FREERUN.
- R9: While LOCKED, `freq_word` follows `cw_in` one cycle later. The average settles within 2^AVG_SH-1 below a constant positive `cw_in`.
- R10: On each switch, `buildout` loads `ph_err`, saturated to plus or minus MAX_OFS.
- R11: Outside a load, `buildout` moves toward zero by at most STEP, no more than once every SLEW_DIV cycles, and reaches zero.
- R12: The `mode` encoding is FREERUN=0, ACQUIRE=1, LOCKED=2, HOLDOVER=3, SWITCHING=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | NREF | One-cycle edge strobe per reference |
| prio_order | input | NREF*IW | Reference index for each priority rank, rank 0 in the low field |
| lock_det | input | 1 | Loop lock indication |
| cw_in | input | FW | Signed frequency control word from the loop filter |
| ph_err | input | PW | Signed phase offset between the output and the selected reference |
| mode | output | 3 | Current mode (R12 encoding) |
| active_sel | output | IW | Index of the active reference |
| ref_valid | output | NREF | Per-reference usable flags |
| freq_word | output | FW | Frequency word sent to the oscillator |
| buildout | output | PW | Phase build-out to subtract from `ph_err` |

## Verification
The assertions assume that `ref_edge` strobes are single-cycle and already synchronised to `clk`. They also assume that `prio_order` stays stable while a selection is being made. The stimulus meets both assumptions by generating every strobe from a common cycle counter on the falling clock edge, with all references phase aligned. The priority order changes only while the machine is in free-run. The slope assertion exempts the load cycle, because a switch is allowed to reload the build-out register from `ph_err`.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [2:0] {
    M_FREERUN   = 3'd0,
    M_ACQUIRE   = 3'd1,
    M_LOCKED    = 3'd2,
    M_HOLDOVER  = 3'd3,
    M_SWITCHING = 3'd4
  } mode_e;
endpackage

// File: rtl/ref_monitor.sv
module ref_monitor #(
  parameter int LOSS_WIN = 16,
  parameter int QUAL_N   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic valid
);
  localparam int GW = $clog2(LOSS_WIN + 1);
  localparam int QW = $clog2(QUAL_N + 1);

  logic [GW-1:0] gap;
  logic [QW-1:0] qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= '0;
      qual  <= '0;
      valid <= 1'b0;
    end else if (edge_i) begin
      gap <= '0;
      if (qual < QW'(QUAL_N)) qual <= qual + 1'b1;
      if (qual >= QW'(QUAL_N - 1)) valid <= 1'b1;
    end else if (gap == GW'(LOSS_WIN - 1)) begin
      valid <= 1'b0;
      qual  <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R2: the silence counter never passes the window
  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(gap) < LOSS_WIN);
  // R3: usable only on the cycle after an edge
  assert_rise_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(edge_i));
  // R2: loss only after an edgeless cycle
  assert_fall_on_silence_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(valid) |-> !$past(edge_i));
endmodule

// File: rtl/freq_hold.sv
module freq_hold
  import refsel_pkg::*;
#(
  parameter int FW     = 24,
  parameter int AVG_SH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mode_e                mode,
  input  logic signed [FW-1:0] cw_in,
  output logic signed [FW-1:0] freq_word
);
  logic signed [FW-1:0] avg;
  logic signed [FW:0]   diff;
  logic signed [FW:0]   inc;

  always_comb begin
    diff = {cw_in[FW-1], cw_in} - {avg[FW-1], avg};
    inc  = diff >>> AVG_SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avg       <= '0;
      freq_word <= '0;
    end else begin
      if (mode == M_LOCKED) avg <= avg + inc[FW-1:0];
      case (mode)
        M_HOLDOVER: freq_word <= avg;
        M_FREERUN:  freq_word <= '0;
        default:    freq_word <= cw_in;
      endcase
    end
  end

  // R6: the held word does not move while holdover continues
  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_HOLDOVER && $past(mode) == M_HOLDOVER && $past(mode, 2) == M_HOLDOVER)
      |-> $stable(freq_word));
endmodule

// File: rtl/phase_buildout.sv
module phase_buildout #(
  parameter int PW       = 16,
  parameter int MAX_OFS  = 1000,
  parameter int STEP     = 1,
  parameter int SLEW_DIV = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  logic signed [PW-1:0] ph_err,
  output logic signed [PW-1:0] bo
);
  localparam int TW = (SLEW_DIV > 1) ? $clog2(SLEW_DIV) : 1;
  localparam logic signed [PW-1:0] LIM_P = PW'(MAX_OFS);
  localparam logic signed [PW-1:0] LIM_N = -LIM_P;
  localparam logic signed [PW-1:0] STP   = PW'(STEP);

  logic [TW-1:0]        tick;
  logic signed [PW-1:0] sat;

  always_comb begin
    if (ph_err > LIM_P)      sat = LIM_P;
    else if (ph_err < LIM_N) sat = LIM_N;
    else                     sat = ph_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bo   <= '0;
      tick <= '0;
    end else if (capture) begin
      bo   <= sat;
      tick <= '0;
    end else if (tick == TW'(SLEW_DIV - 1)) begin
      tick <= '0;
      if (bo > STP)       bo <= bo - STP;
      else if (bo < -STP) bo <= bo + STP;
      else                bo <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R11: bounded step per cycle outside a load
  assert_slope_R11: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ((int'(bo) - int'($past(bo)) <= STEP) &&
                  (int'($past(bo)) - int'(bo) <= STEP)));
  // R10: build-out stays inside the clamp
  assert_clamp_R10: assert property (@(posedge clk) disable iff (rst)
    (int'(bo) <= MAX_OFS) && (int'(bo) >= -MAX_OFS));
endmodule

// File: rtl/refsel_core.sv
module refsel_core
  import refsel_pkg::*;
#(
  parameter int NREF     = 3,
  parameter int LOSS_WIN = 16,
  parameter int QUAL_N   = 8,
  parameter int FW       = 24,
  parameter int PW       = 16,
  parameter int AVG_SH   = 4,
  parameter int MAX_OFS  = 1000,
  parameter int STEP     = 1,
  parameter int SLEW_DIV = 64,
  parameter bit HOLD_EN  = 1'b1,
  parameter int HOLD_TMO = 1000000,
  localparam int IW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREF-1:0]      ref_edge,
  input  logic [NREF*IW-1:0]   prio_order,
  input  logic                 lock_det,
  input  logic signed [FW-1:0] cw_in,
  input  logic signed [PW-1:0] ph_err,
  output logic [2:0]           mode,
  output logic [IW-1:0]        active_sel,
  output logic [NREF-1:0]      ref_valid,
  output logic signed [FW-1:0] freq_word,
  output logic signed [PW-1:0] buildout
);
  localparam int HW = $clog2(HOLD_TMO + 1);

  mode_e         mode_q;
  logic [IW-1:0] act_q;
  logic          hist_q;
  logic [HW-1:0] hold_cnt;
  logic          best_ok;
  logic [IW-1:0] best_idx;
  logic          act_ok;

  genvar g;
  generate
    for (g = 0; g < NREF; g++) begin : g_mon
      ref_monitor #(.LOSS_WIN(LOSS_WIN), .QUAL_N(QUAL_N)) u_mon (
        .clk(clk), .rst(rst), .edge_i(ref_edge[g]), .valid(ref_valid[g]));
    end
  endgenerate

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    for (int k = NREF - 1; k >= 0; k--) begin
      if (int'(prio_order[k*IW +: IW]) < NREF && ref_valid[prio_order[k*IW +: IW]]) begin
        best_ok  = 1'b1;
        best_idx = prio_order[k*IW +: IW];
      end
    end
    act_ok = ref_valid[act_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_FREERUN;
      act_q    <= '0;
      hist_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      hold_cnt <= (mode_q == M_HOLDOVER) ? hold_cnt + 1'b1 : '0;
      if (mode_q == M_LOCKED)  hist_q <= 1'b1;
      if (mode_q == M_FREERUN) hist_q <= 1'b0;
      case (mode_q)
        M_FREERUN: if (best_ok) begin
          mode_q <= M_ACQUIRE;
          act_q  <= best_idx;
        end
        M_ACQUIRE, M_LOCKED: begin
          if (!act_ok) begin
            if (best_ok) begin
              mode_q <= M_SWITCHING;
              act_q  <= best_idx;
            end else if (HOLD_EN && (hist_q || mode_q == M_LOCKED)) begin
              mode_q <= M_HOLDOVER;
            end else begin
              mode_q <= M_FREERUN;
            end
          end else if (mode_q == M_ACQUIRE && lock_det) begin
            mode_q <= M_LOCKED;
          end else if (mode_q == M_LOCKED && !lock_det) begin
            mode_q <= M_ACQUIRE;
          end
        end
        M_SWITCHING: mode_q <= M_ACQUIRE;
        M_HOLDOVER: begin
          if (best_ok) begin
            mode_q <= M_SWITCHING;
            act_q  <= best_idx;
          end else if (hold_cnt == HW'(HOLD_TMO - 1)) begin
            mode_q <= M_FREERUN;
          end
        end
        default: mode_q <= M_FREERUN;
      endcase
    end
  end

  freq_hold #(.FW(FW), .AVG_SH(AVG_SH)) u_freq (
    .clk(clk), .rst(rst), .mode(mode_q), .cw_in(cw_in), .freq_word(freq_word));

  phase_buildout #(.PW(PW), .MAX_OFS(MAX_OFS), .STEP(STEP), .SLEW_DIV(SLEW_DIV)) u_bo (
    .clk(clk), .rst(rst), .capture(mode_q == M_SWITCHING), .ph_err(ph_err), .bo(buildout));

  assign mode       = mode_q;
  assign active_sel = act_q;

  // R1: active index in range
  assert_active_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(act_q) < NREF);
  // R5: a lost active reference is never kept while locked
  assert_leave_on_loss_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_LOCKED && !act_ok) |=> mode_q != M_LOCKED);
  // R5: switching lasts one cycle and leads to acquisition
  assert_switch_once_R5: assert property (@(posedge clk) disable iff (rst)
    mode_q == M_SWITCHING |=> mode_q == M_ACQUIRE);
  // R8: without holdover the state is never entered
  assert_no_holdover_R8: assert property (@(posedge clk) disable iff (rst)
    !HOLD_EN |-> mode_q != M_HOLDOVER);
endmodule

// File: tb/sim_refsel_core.sv
module sim_refsel_core;
  localparam int CLK_PERIOD = 10;
  localparam int NREF = 3, LOSS_WIN = 8, QUAL_N = 4, FW = 16, PW = 12;
  localparam int AVG_SH = 2, MAX_OFS = 300, STEP = 2, SLEW_DIV = 4, HOLD_TMO = 64;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NREF-1:0] ref_edge = '0;
  logic [NREF*IW-1:0] prio_order = '0;
  logic lock_det = 1'b0;
  logic signed [FW-1:0] cw_in = '0;
  logic signed [PW-1:0] ph_err = '0;
  logic [2:0] mode, mode1;
  logic [IW-1:0] active_sel, active1;
  logic [NREF-1:0] ref_valid, valid1;
  logic signed [FW-1:0] freq_word, freq1;
  logic signed [PW-1:0] buildout, bo1;

  int en[NREF];
  int per[NREF];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_core #(.NREF(NREF), .LOSS_WIN(LOSS_WIN), .QUAL_N(QUAL_N), .FW(FW), .PW(PW),
    .AVG_SH(AVG_SH), .MAX_OFS(MAX_OFS), .STEP(STEP), .SLEW_DIV(SLEW_DIV),
    .HOLD_EN(1'b1), .HOLD_TMO(HOLD_TMO)) u0 (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .prio_order(prio_order),
    .lock_det(lock_det), .cw_in(cw_in), .ph_err(ph_err), .mode(mode),
    .active_sel(active_sel), .ref_valid(ref_valid), .freq_word(freq_word),
    .buildout(buildout));

  refsel_core #(.NREF(NREF), .LOSS_WIN(LOSS_WIN), .QUAL_N(QUAL_N), .FW(FW), .PW(PW),
    .AVG_SH(AVG_SH), .MAX_OFS(MAX_OFS), .STEP(STEP), .SLEW_DIV(SLEW_DIV),
    .HOLD_EN(1'b0), .HOLD_TMO(HOLD_TMO)) u1 (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .prio_order(prio_order),
    .lock_det(lock_det), .cw_in(cw_in), .ph_err(ph_err), .mode(mode1),
    .active_sel(active1), .ref_valid(valid1), .freq_word(freq1),
    .buildout(bo1));

  // edge strobes from one counter, all references phase aligned
  initial begin
    for (int i = 0; i < NREF; i++) begin en[i] = 0; per[i] = 4; end
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NREF; i++)
        ref_edge[i] = (en[i] != 0) && (cyc % per[i] == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NREF*IW-1:0] order(input int r0, input int r1, input int r2);
    return {IW'(r2), IW'(r1), IW'(r0)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, bmax, prev, cur, viol, last_chg;
    bit seen_sw;
    prio_order = order(2, 0, 1);
    wait_neg(5);
    rst = 1'b0;
    wait_neg(2);
    // reset state, R12 encoding FREERUN=0
    chk(mode == 3'd0, "R12 reset mode", mode, 0);
    chk(ref_valid == '0, "R3 reset valid", ref_valid, 0);
    chk(freq_word == 0 && buildout == 0, "R7 reset outputs", freq_word, 0);

    // R4: highest rank (ref 2) chosen from free-run
    for (int i = 0; i < NREF; i++) en[i] = 1;
    wait_neg(30);
    chk(ref_valid == 3'b111, "R3 qualified", ref_valid, 7);
    chk(mode == 3'd1, "R4 acquire mode", mode, 1);
    chk(active_sel == 2, "R4 rank0 select", active_sel, 2);
    chk(active1 == 2, "R1 single active", active1, 2);

    // R9: lock and follow the loop word
    lock_det = 1'b1;
    cw_in = 16'sd1000;
    wait_neg(100);
    chk(mode == 3'd2, "R4 locked", mode, 2);
    chk(freq_word == 1000, "R9 follows cw", freq_word, 1000);

    // R5/R10/R11: active ref 2 fails, switch to rank1 = ref 0
    ph_err = 12'sd500;
    en[2] = 0;
    bmax = 0; prev = int'(buildout); viol = 0; last_chg = 0;
    for (int k = 1; k <= 720; k++) begin
      @(negedge clk);
      cur = int'(buildout);
      if (cur > bmax) bmax = cur;
      if (cur != prev) begin
        if (prev != 0) begin
          if (prev - cur > STEP || cur > prev) viol++;
          if (k - last_chg < SLEW_DIV) viol++;
        end
        last_chg = k;
      end
      prev = cur;
    end
    chk(ref_valid[2] == 1'b0, "R2 lost ref", ref_valid, 3);
    chk(mode == 3'd2 && active_sel == 0, "R5 switch to rank1", active_sel, 0);
    chk(bmax == MAX_OFS, "R10 saturated load", bmax, MAX_OFS);
    chk(viol == 0, "R11 slope bound", viol, 0);
    chk(buildout == 0, "R11 decays to zero", buildout, 0);

    // R3: edges spaced wider than the window never qualify
    per[2] = 10; en[2] = 1;
    wait_neg(100);
    chk(ref_valid[2] == 1'b0, "R3 slow edges", ref_valid[2], 0);
    per[2] = 4;
    wait_neg(30);
    chk(ref_valid[2] == 1'b1, "R3 requalify", ref_valid[2], 1);
    chk(active_sel == 0 && mode == 3'd2, "R5 non-revertive", active_sel, 0);

    // R2: exact loss latency on standby ref 1
    do @(posedge clk); while (!ref_edge[1]);
    en[1] = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (ref_valid[1] && n < 100);
    chk(n == LOSS_WIN + 1, "R2 loss latency", n, LOSS_WIN + 1);
    en[1] = 1;
    wait_neg(30);

    // R6/R8: total loss
    for (int i = 0; i < NREF; i++) en[i] = 0;
    wait_neg(LOSS_WIN + 6);
    chk(mode == 3'd3, "R6 holdover", mode, 3);
    chk(freq_word <= 1000 && freq_word >= 1000 - (2**AVG_SH - 1), "R6 averaged word", freq_word, 1000);
    n = int'(freq_word);
    chk(mode1 == 3'd0 && freq1 == 0, "R8 no-holdover freerun", mode1, 0);
    cw_in = 16'sd7000;
    wait_neg(10);
    chk(int'(freq_word) == n, "R6 ignores cw_in", freq_word, n);

    // R7: timeout
    wait_neg(HOLD_TMO + 6);
    chk(mode == 3'd0 && freq_word == 0, "R7 timeout freerun", mode, 0);

    // R4 with a new order: rank0 = ref 1
    lock_det = 1'b0;
    prio_order = order(1, 0, 2);
    en[0] = 1; en[1] = 1;
    wait_neg(30);
    chk(mode == 3'd1 && active_sel == 1, "R4 new order", active_sel, 1);
    lock_det = 1'b1;
    wait_neg(15);
    en[0] = 0; en[1] = 0;
    wait_neg(LOSS_WIN + 6);
    chk(mode == 3'd3, "R6 holdover again", mode, 3);

    // R5 return during holdover, R10 unsaturated negative load
    lock_det = 1'b0;
    ph_err = -12'sd100;
    en[0] = 1;
    seen_sw = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (mode == 3'd4) seen_sw = 1'b1;
    end
    chk(seen_sw, "R12 switching code 4", seen_sw, 1);
    chk(mode == 3'd1 && active_sel == 0, "R5 holdover return", active_sel, 0);
    chk(buildout >= -100 && buildout <= -80, "R10 negative load", buildout, -100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule